// File: doc/BRIEF.md
# Calendar Timekeeper with Alarm

This block keeps a running calendar: seconds, minutes, hours, weekday, day of month, month and a two-digit year. It counts in binary inside a calendar counter. A separate bank of time registers shows the host a formatted copy of that count. The copy is written in BCD or plain binary, and with hours in 12-hour or 24-hour form. A 1 Hz enable starts each update. Before the new time appears in the registers, an update-in-progress window opens and stays open for a fixed number of 32768 Hz enable pulses.

When each update closes, the block does three things. It copies the new time into the register bank, unless the host holds the bank frozen for editing. It compares the time against a three-field alarm, where any field can be made a wildcard. It emits one-cycle strobes for update-ended, alarm and interrupt request. A host bus adapter sits outside the block. It drives the write and read ports and turns the strobes into a flag register.

Register addresses: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes, 9 alarm hours, 10 oscillator control, 11 mode control. Any other address reads as zero and ignores writes.

Top module: `timekeeper_core`

## Requirements
- R1: A `tick_1hz` pulse advances the time only when bits 6:4 of the oscillator control (address 10) equal 3'b010. With any other value the pulse is dropped: the time, `uip` and the strobes are unchanged. Reset loads address 10 with 0x20.
- R2: Mode control (address 11) bit 2 selects the register format. When set, registers hold plain binary. When clear, they hold BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. The same format applies to register writes and to the alarm fields.
- R3: Mode control bit 1 selects the hour format. When set, hours run 0 to 23. When clear, the hour register holds the hour modulo 12, and bit 7 is set for hours 12 to 23. A write to the hour register in 12-hour form with bit 7 set loads the hour plus 12.
- R4: Seconds and minutes wrap after 59 and hours wrap after 23. Weekday runs 1 to 7 and wraps to 1. The day of month wraps after the last day of the month. Month runs 1 to 12. The year runs 00 to 99 and wraps to 00.
- R5: The full year is `BASE_YEAR` (default 2000) plus the two-digit year. February has 29 days when that full year is divisible by 4, except for years divisible by 100 that are not also divisible by 400. Months 4, 6, 9 and 11 have 30 days. All other months have 31.
- R6: An accepted tick sets `uip`, unless mode control bit 7 is set. `uip` is also read as bit 7 of address 10. It stays high for exactly `WIN_TICKS` (default 8) `tick_32k` pulses. At the edge of the last of those pulses, the new time is written into registers 0 to 6 and `uip` clears.
- R7: While mode control bit 7 (freeze) is set, the end of an update does not write registers 0 to 6. A time-register write made while freeze is clear reloads the counter at once. Clearing freeze reloads the counter from registers 0 to 6. Writing mode control with freeze set clears `uip` and forces bit 4 to 0.
- R8: An alarm field matches any value when its bits 7:6 are both 1. If all three alarm fields match the new time at the end of an update and mode control bit 5 is set, `af_stb` and `irq_stb` both pulse.
- R9: `uf_stb` pulses at the end of every update. `irq_stb` also pulses then when mode control bit 4 is set.
- R10: A mode-control write that leaves freeze clear and changes bit 2 or bit 1 rewrites registers 0 to 6 in the new format at the same edge.
- R11: After reset the registers read 00:00:00, weekday 1, day 1, month 1, year 00. The alarms read 0, address 10 reads 0x20, and address 11 reads 0x02. `uip` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle enable that requests a one-second update |
| tick_32k | input | 1 | One-cycle enable at 32768 Hz that times the update window |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Combinational read data |
| uip | output | 1 | Update in progress |
| uf_stb | output | 1 | Update-ended strobe |
| af_stb | output | 1 | Alarm strobe |
| irq_stb | output | 1 | Interrupt request strobe |

## Verification
- Writes take effect at the edge that samples them, so a read half a cycle later already shows the reloaded or reformatted registers.
- `uip` rises at the edge that takes the 1 Hz tick. It is sampled before each of the following window pulses, which confirms it stays high for exactly the window length.
- The published time and all three strobes are due at the edge of the last window pulse. The bench samples them at the next falling edge, and checks that no strobe appeared at any earlier falling edge of the window.
- Expected register values come from an arithmetic calendar model in the bench. Sweeps run through minutes, hours, a year rollover and every month end in a leap and a common year.

// File: rtl/tkc_pkg.sv
package tkc_pkg;

   typedef struct packed {
      logic [6:0] yr;
      logic [3:0] mon;
      logic [4:0] dom;
      logic [2:0] dow;
      logic [4:0] hr;
      logic [5:0] min;
      logic [5:0] sec;
   } tkc_time_t;

   localparam int unsigned TKC_NTIME = 7;
   typedef logic [TKC_NTIME-1:0][7:0] tkc_regs_t;

   localparam logic [3:0] AD_ALS  = 4'd7;
   localparam logic [3:0] AD_ALM  = 4'd8;
   localparam logic [3:0] AD_ALH  = 4'd9;
   localparam logic [3:0] AD_CTLA = 4'd10;
   localparam logic [3:0] AD_CTLB = 4'd11;

   localparam int B_FRZ = 7;
   localparam int B_AIE = 5;
   localparam int B_UIE = 4;
   localparam int B_BIN = 2;
   localparam int B_H24 = 1;

   localparam tkc_time_t TKC_RST_TIME = '{yr: 7'd0, mon: 4'd1, dom: 5'd1, dow: 3'd1,
                                          hr: 5'd0, min: 6'd0, sec: 6'd0};

   function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
      if (bin) return {1'b0, v};
      return {4'(v / 7'd10), 4'(v % 7'd10)};
   endfunction

   function automatic logic [6:0] dec_val(input logic [7:0] r, input logic bin);
      if (bin) return r[6:0];
      return ({3'b0, r[7:4]} * 7'd10) + {3'b0, r[3:0]};
   endfunction

   function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin,
                                           input logic h24);
      logic [6:0] v;
      logic       pm;
      pm = !h24 && (h >= 5'd12);
      v  = {2'b0, h};
      if (pm) v = v - 7'd12;
      return enc_val(v, bin) | {pm, 7'b0};
   endfunction

   function automatic logic [4:0] dec_hour(input logic [7:0] r, input logic bin,
                                           input logic h24);
      logic [6:0] v;
      if (h24) begin
         v = dec_val(r, bin);
      end else begin
         v = dec_val({1'b0, r[6:0]}, bin);
         if (r[7]) v = v + 7'd12;
      end
      return 5'(v);
   endfunction

   function automatic tkc_regs_t enc_time(input tkc_time_t t, input logic bin,
                                          input logic h24);
      tkc_regs_t r;
      r[0] = enc_val({1'b0, t.sec}, bin);
      r[1] = enc_val({1'b0, t.min}, bin);
      r[2] = enc_hour(t.hr, bin, h24);
      r[3] = enc_val({4'b0, t.dow}, bin);
      r[4] = enc_val({2'b0, t.dom}, bin);
      r[5] = enc_val({3'b0, t.mon}, bin);
      r[6] = enc_val(t.yr, bin);
      return r;
   endfunction

   function automatic tkc_time_t dec_time(input tkc_regs_t r, input logic bin,
                                          input logic h24);
      tkc_time_t t;
      t.sec = 6'(dec_val(r[0], bin));
      t.min = 6'(dec_val(r[1], bin));
      t.hr  = dec_hour(r[2], bin, h24);
      t.dow = 3'(dec_val(r[3], bin));
      t.dom = 5'(dec_val(r[4], bin));
      t.mon = 4'(dec_val(r[5], bin));
      t.yr  = dec_val(r[6], bin);
      return t;
   endfunction

   function automatic logic is_leap(input logic [15:0] y);
      return (((y % 16'd4) == 16'd0) && ((y % 16'd100) != 16'd0)) ||
             ((y % 16'd400) == 16'd0);
   endfunction

   function automatic logic [4:0] days_in_month(input logic [3:0] mon, input logic leap);
      case (mon)
         4'd2:                    return leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
         default:                 return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/tkc_calendar.sv
module tkc_calendar
   import tkc_pkg::*;
#(
   parameter int BASE_YEAR = 2000
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      adv,
   input  logic      load,
   input  tkc_time_t load_val,
   output tkc_time_t now
);

   if (BASE_YEAR < 1 || BASE_YEAR > 65000) begin : g_bad_base
      $error("tkc_calendar: BASE_YEAR out of range");
   end

   tkc_time_t   cur, nxt;
   logic [15:0] full_yr;
   logic [4:0]  mdays;

   always_comb begin
      full_yr = 16'(BASE_YEAR) + {9'b0, cur.yr};
      mdays   = days_in_month(cur.mon, is_leap(full_yr));
      nxt     = cur;
      if (cur.sec < 6'd59) begin
         nxt.sec = cur.sec + 6'd1;
      end else begin
         nxt.sec = 6'd0;
         if (cur.min < 6'd59) begin
            nxt.min = cur.min + 6'd1;
         end else begin
            nxt.min = 6'd0;
            if (cur.hr < 5'd23) begin
               nxt.hr = cur.hr + 5'd1;
            end else begin
               nxt.hr  = 5'd0;
               nxt.dow = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
               if (cur.dom < mdays) begin
                  nxt.dom = cur.dom + 5'd1;
               end else begin
                  nxt.dom = 5'd1;
                  if (cur.mon < 4'd12) begin
                     nxt.mon = cur.mon + 4'd1;
                  end else begin
                     nxt.mon = 4'd1;
                     nxt.yr  = (cur.yr >= 7'd99) ? 7'd0 : cur.yr + 7'd1;
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cur <= TKC_RST_TIME;
      else if (load) cur <= load_val;
      else if (adv)  cur <= nxt;
   end

   assign now = cur;

endmodule

// File: rtl/tkc_window.sv
module tkc_window #(
   parameter int WIN_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic busy,
   output logic done
);

   if (WIN_TICKS < 1) begin : g_bad_win
      $error("tkc_window: WIN_TICKS must be at least 1");
   end

   localparam int CW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIN_TICKS - 1);

   logic [CW-1:0] cnt;

   assign done = busy && tick && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy && tick) begin
         if (cnt == LAST) busy <= 1'b0;
         else             cnt  <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/tkc_alarm.sv
module tkc_alarm
   import tkc_pkg::*;
#(
   parameter int NFLD = 3
) (
   input  logic [NFLD-1:0][7:0] al,
   input  logic                 bin,
   input  logic                 h24,
   input  tkc_time_t            now,
   output logic                 match
);

   if (NFLD != 3) begin : g_bad_nfld
      $error("tkc_alarm: exactly three fields are supported");
   end

   logic [6:0]      have [NFLD];
   logic [6:0]      want [NFLD];
   logic [NFLD-1:0] hit;

   assign have[0] = {1'b0, now.sec};
   assign have[1] = {1'b0, now.min};
   assign have[2] = {2'b0, now.hr};

   for (genvar i = 0; i < NFLD; i++) begin : g_fld
      if (i == 2) begin : g_hour
         assign want[i] = {2'b0, dec_hour(al[i], bin, h24)};
      end else begin : g_plain
         assign want[i] = dec_val(al[i], bin);
      end
      assign hit[i] = (al[i][7:6] == 2'b11) || (want[i] == have[i]);
   end

   assign match = &hit;

endmodule

// File: rtl/timekeeper_core.sv
module timekeeper_core
   import tkc_pkg::*;
#(
   parameter int BASE_YEAR = 2000,
   parameter int WIN_TICKS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_1hz,
   input  logic       tick_32k,
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [3:0] rd_addr,
   output logic [7:0] rd_data,
   output logic       uip,
   output logic       uf_stb,
   output logic       af_stb,
   output logic       irq_stb
);

   tkc_regs_t       tr, tr_m;
   logic [2:0][7:0] alm;
   logic [6:0]      ctl_a;
   logic [7:0]      ctl_b;
   logic            uip_q;

   tkc_time_t now, ld_val, pub_src;
   logic      osc_run, frz, tick_ok, win_busy, done, al_hit;
   logic      wr_time, wr_a, wr_b, cal_load, fmt_chg;

   assign osc_run = (ctl_a[6:4] == 3'b010);
   assign frz     = ctl_b[B_FRZ];
   assign tick_ok = tick_1hz && osc_run && !win_busy;
   assign wr_time = wr_en && (wr_addr < 4'(TKC_NTIME));
   assign wr_a    = wr_en && (wr_addr == AD_CTLA);
   assign wr_b    = wr_en && (wr_addr == AD_CTLB);

   always_comb begin
      tr_m = tr;
      for (int i = 0; i < TKC_NTIME; i++)
         if (wr_time && (wr_addr == 4'(i))) tr_m[i] = wr_data;
   end

   assign ld_val   = dec_time(tr_m, ctl_b[B_BIN], ctl_b[B_H24]);
   assign cal_load = (wr_time && !frz) || (wr_b && frz && !wr_data[B_FRZ]);
   assign fmt_chg  = wr_b && !wr_data[B_FRZ] &&
                     (wr_data[B_BIN:B_H24] != ctl_b[B_BIN:B_H24]);
   assign pub_src  = cal_load ? ld_val : now;

   tkc_calendar #(.BASE_YEAR(BASE_YEAR)) u_cal (
      .clk(clk), .rst_n(rst_n), .adv(tick_ok), .load(cal_load),
      .load_val(ld_val), .now(now)
   );

   tkc_window #(.WIN_TICKS(WIN_TICKS)) u_win (
      .clk(clk), .rst_n(rst_n), .start(tick_ok), .tick(tick_32k),
      .busy(win_busy), .done(done)
   );

   tkc_alarm #(.NFLD(3)) u_alm (
      .al(alm), .bin(ctl_b[B_BIN]), .h24(ctl_b[B_H24]), .now(now), .match(al_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              tr <= enc_time(TKC_RST_TIME, 1'b0, 1'b1);
      else if (wr_time)        tr <= tr_m;
      else if (fmt_chg)        tr <= enc_time(pub_src, wr_data[B_BIN], wr_data[B_H24]);
      else if (done && !frz)   tr <= enc_time(now, ctl_b[B_BIN], ctl_b[B_H24]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm   <= '0;
         ctl_a <= 7'h20;
         ctl_b <= 8'h02;
      end else if (wr_en) begin
         if (wr_addr == AD_ALS) alm[0] <= wr_data;
         if (wr_addr == AD_ALM) alm[1] <= wr_data;
         if (wr_addr == AD_ALH) alm[2] <= wr_data;
         if (wr_a)              ctl_a  <= wr_data[6:0];
         if (wr_b)              ctl_b  <= wr_data[B_FRZ] ? (wr_data & ~8'h10) : wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          uip_q <= 1'b0;
      else if (wr_b && wr_data[B_FRZ])     uip_q <= 1'b0;
      else if (tick_ok && !frz)            uip_q <= 1'b1;
      else if (done)                       uip_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uf_stb  <= 1'b0;
         af_stb  <= 1'b0;
         irq_stb <= 1'b0;
      end else begin
         uf_stb  <= done;
         af_stb  <= done && ctl_b[B_AIE] && al_hit;
         irq_stb <= done && ((ctl_b[B_AIE] && al_hit) || ctl_b[B_UIE]);
      end
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < TKC_NTIME; i++)
         if (rd_addr == 4'(i)) rd_data = tr[i];
      case (rd_addr)
         AD_ALS:  rd_data = alm[0];
         AD_ALM:  rd_data = alm[1];
         AD_ALH:  rd_data = alm[2];
         AD_CTLA: rd_data = {uip_q, ctl_a};
         AD_CTLB: rd_data = ctl_b;
         default: ;
      endcase
   end

   assign uip = uip_q;

endmodule

// File: rtl/timekeeper_core_chk.sv
module timekeeper_core_chk (
   input logic clk,
   input logic rst_n,
   input logic uip,
   input logic uf_stb,
   input logic af_stb,
   input logic irq_stb,
   input logic win_busy,
   input logic osc_run
);

   // R6: the host-visible flag is only up inside a running window
   a_r6_uip_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      uip |-> win_busy);

   // R6: the flag is down when the update-ended strobe appears
   a_r6_uip_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      uf_stb |-> !uip);

   // R9: update-ended is a single-cycle strobe
   a_r9_uf_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      uf_stb |=> !uf_stb);

   // R9: interrupt requests only come with the end of an update
   a_r9_irq_with_update: assert property (@(posedge clk) disable iff (!rst_n)
      irq_stb |-> uf_stb);

   // R8: an alarm always requests an interrupt at the end of an update
   a_r8_alarm_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      af_stb |-> (irq_stb && uf_stb));

   // R1: a stopped oscillator never opens a window
   a_r1_stopped_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_run && !win_busy) |=> !win_busy);

endmodule

bind timekeeper_core timekeeper_core_chk u_chk (
   .clk(clk), .rst_n(rst_n), .uip(uip), .uf_stb(uf_stb), .af_stb(af_stb),
   .irq_stb(irq_stb), .win_busy(win_busy), .osc_run(osc_run)
);

// File: tb/timekeeper_core_test.sv
module timekeeper_core_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0, tick_32k = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0, rd_data;
   logic       uip, uf_stb, af_stb, irq_stb;

   always #10 clk = ~clk;

   timekeeper_core uut (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_32k(tick_32k),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .uip(uip), .uf_stb(uf_stb), .af_stb(af_stb), .irq_stb(irq_stb)
   );

   int total = 0, bad = 0;
   int ms, mm, mh, mdw, mdd, mmo, my;
   logic [7:0] breg = 8'h02;
   int s_uip0, s_pulses, s_mida, s_uf, s_af, s_irq, s_early, s_uipend;

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   function automatic int fmt(input int v, input bit bin);
      return bin ? v : ((v / 10) * 16 + (v % 10));
   endfunction

   function automatic int fmt_hr(input int h, input bit bin, input bit h24);
      if (h24) return fmt(h, bin);
      return fmt(h % 12, bin) + ((h >= 12) ? 128 : 0);
   endfunction

   // base year 2000: in 2000..2099 a year is leap exactly when yy is a multiple of 4
   function automatic int mdays(input int mo, input int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic adv_model;
      ms++;
      if (ms == 60) begin
         ms = 0; mm++;
         if (mm == 60) begin
            mm = 0; mh++;
            if (mh == 24) begin
               mh = 0;
               mdw = (mdw == 7) ? 1 : mdw + 1;
               mdd++;
               if (mdd > mdays(mmo, my)) begin
                  mdd = 1; mmo++;
                  if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
               end
            end
         end
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic check_time(input string tag);
      logic [7:0] d;
      rd(0, d); chk({tag, " sec"},  d, fmt(ms, breg[2]));
      rd(1, d); chk({tag, " min"},  d, fmt(mm, breg[2]));
      rd(2, d); chk({tag, " hour"}, d, fmt_hr(mh, breg[2], breg[1]));
      rd(3, d); chk({tag, " wday"}, d, fmt(mdw, breg[2]));
      rd(4, d); chk({tag, " mday"}, d, fmt(mdd, breg[2]));
      rd(5, d); chk({tag, " mon"},  d, fmt(mmo, breg[2]));
      rd(6, d); chk({tag, " year"}, d, fmt(my, breg[2]));
   endtask

   task automatic load_time(input int h, input int m, input int s, input int dw,
                            input int dd, input int mo, input int y);
      ms = s; mm = m; mh = h; mdw = dw; mdd = dd; mmo = mo; my = y;
      wr(11, breg | 8'h80);
      wr(0, 8'(fmt(s, breg[2])));
      wr(1, 8'(fmt(m, breg[2])));
      wr(2, 8'(fmt_hr(h, breg[2], breg[1])));
      wr(3, 8'(fmt(dw, breg[2])));
      wr(4, 8'(fmt(dd, breg[2])));
      wr(5, 8'(fmt(mo, breg[2])));
      wr(6, 8'(fmt(y, breg[2])));
      wr(11, breg);
   endtask

   // one 1 Hz tick followed by eight window pulses; results land at the last pulse edge
   task automatic do_second(input bit advance);
      logic [7:0] d;
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      s_uip0 = uip; s_pulses = 0; s_early = 0; s_mida = 0;
      for (int k = 0; k < 8; k++) begin
         if (uip) s_pulses++;
         if (k == 3) begin rd(10, d); s_mida = d; end
         tick_32k = 1'b1;
         @(negedge clk); tick_32k = 1'b0;
         if (k < 7) s_early = s_early | uf_stb | af_stb | irq_stb;
      end
      s_uf = uf_stb; s_af = af_stb; s_irq = irq_stb; s_uipend = uip;
      @(negedge clk);
      if (advance) adv_model;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      ms = 0; mm = 0; mh = 0; mdw = 1; mdd = 1; mmo = 1; my = 0;
      check_time("R11 reset");
      rd(7, d);  chk("R11 alarm sec", d, 0);
      rd(9, d);  chk("R11 alarm hour", d, 0);
      rd(10, d); chk("R11 osc ctl", d, 8'h20);
      rd(11, d); chk("R11 mode ctl", d, 8'h02);
      chk("R11 strobes", {uip, uf_stb, af_stb, irq_stb}, 0);

      // R6 window timing and publish, R9 update-ended without interrupt
      do_second(1);
      chk("R6 uip rises", s_uip0, 1);
      chk("R6 uip pulses", s_pulses, 8);
      chk("R6 uip read bit7", s_mida, 8'hA0);
      chk("R6 uip falls", s_uipend, 0);
      chk("R6 no early strobe", s_early, 0);
      chk("R9 uf", s_uf, 1);
      chk("R9 no irq", s_irq, 0);
      check_time("R6 publish");

      // R4 sweep across midnight and year rollover, BCD 24h
      load_time(23, 58, 30, 7, 31, 12, 99);
      check_time("R7 load");
      for (int n = 0; n < 100; n++) begin
         do_second(1);
         check_time("R4 sweep");
      end
      chk("R4 year wrapped", my, 0);

      // R10 format change to binary 12h republishes at once, then R2 R3 sweep
      breg = 8'h04; wr(11, breg);
      check_time("R10 to bin12");
      load_time(11, 59, 20, 2, 15, 6, 7);
      for (int n = 0; n < 60; n++) begin
         do_second(1);
         check_time("R3 bin12 sweep");
      end
      breg = 8'h00; wr(11, breg);
      check_time("R2 bcd12");
      load_time(0, 0, 0, 1, 1, 1, 0);
      rd(2, d); chk("R3 midnight 12h", d, 0);
      wr(2, 8'h91); mh = 23;
      breg = 8'h02; wr(11, breg);
      rd(2, d); chk("R3 pm write", d, 8'h23);
      check_time("R10 back to bcd24");
      breg = 8'h06; wr(11, breg);
      rd(2, d); chk("R2 binary hour", d, 23);

      // R4 R5 every month end in leap year 00 and common year 01
      breg = 8'h02; wr(11, breg);
      for (int y = 0; y < 2; y++)
         for (int mo = 1; mo <= 12; mo++) begin
            load_time(23, 59, 59, 4, mdays(mo, y), mo, y);
            do_second(1);
            check_time("R5 month end");
         end
      load_time(23, 59, 59, 1, 28, 2, 0);
      do_second(1);
      rd(4, d); chk("R5 leap feb29", d, 8'h29);

      // R1 oscillator gating
      load_time(8, 30, 15, 3, 10, 10, 10);
      wr(10, 8'h00);
      do_second(0);
      chk("R1 stopped uip", s_uip0, 0);
      chk("R1 stopped uf", s_uf, 0);
      check_time("R1 stopped hold");
      wr(10, 8'h60);
      do_second(0);
      check_time("R1 code 110 hold");
      wr(10, 8'h20);
      do_second(1);
      check_time("R1 running");

      // R7 freeze mode
      load_time(10, 20, 30, 5, 12, 3, 4);
      wr(11, 8'h92);
      rd(11, d); chk("R7 uie forced off", d, 8'h82);
      do_second(0);
      chk("R7 no uip in freeze", s_uip0, 0);
      chk("R7 uf in freeze", s_uf, 1);
      check_time("R7 frozen regs");
      wr(0, 8'h45); ms = 45;
      do_second(0);
      check_time("R7 frozen after write");
      wr(11, 8'h02);
      do_second(1);
      check_time("R7 reload on unfreeze");
      wr(0, 8'h50); ms = 50;
      do_second(1);
      check_time("R7 direct write");

      // R8 alarm
      breg = 8'h22; wr(11, breg);
      wr(7, 8'h05); wr(8, 8'h00); wr(9, 8'h00);
      load_time(0, 0, 4, 1, 1, 1, 1);
      do_second(1);
      chk("R8 alarm hit af", s_af, 1);
      chk("R8 alarm hit irq", s_irq, 1);
      do_second(1);
      chk("R8 alarm miss", s_af, 0);
      chk("R8 alarm miss irq", s_irq, 0);
      wr(7, 8'h10); wr(8, 8'hC0); wr(9, 8'hC0);
      load_time(5, 17, 8, 1, 1, 1, 1);
      do_second(1);
      chk("R8 partial wild miss", s_af, 0);
      do_second(1);
      chk("R8 partial wild hit", s_af, 1);
      wr(7, 8'hC0);
      do_second(1);
      chk("R8 all wild", s_af, 1);
      breg = 8'h20; wr(11, breg);
      wr(7, 8'h00); wr(8, 8'h00); wr(9, 8'h81);
      load_time(12, 59, 59, 1, 1, 1, 1);
      do_second(1);
      chk("R8 12h pm alarm", s_af, 1);
      breg = 8'h02; wr(11, breg);
      wr(7, 8'hC0); wr(8, 8'hC0); wr(9, 8'hC0);
      do_second(1);
      chk("R8 aie off af", s_af, 0);
      chk("R8 aie off irq", s_irq, 0);

      // R9 update interrupt enable
      breg = 8'h12; wr(11, breg);
      do_second(1);
      chk("R9 uie irq", s_irq, 1);
      chk("R9 uie uf", s_uf, 1);
      chk("R9 uie no af", s_af, 0);
      breg = 8'h02; wr(11, breg);
      do_second(1);
      chk("R9 uie off irq", s_irq, 0);
      check_time("R9 time");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule